// File: doc/BRIEF.md
# External Data Space Router

This block sits between a processor's external-data request port and two possible targets: an 8 KB on-chip RAM and an external memory bus. Each request carries a 16-bit address, a write byte and a write/read flag. The router chooses the target from a two-bit mode input and the address. It runs the access on the chosen target. It then returns the read byte together with a one-cycle done flag.

The on-chip RAM itself sits beside the router, and the router drives its enable, write, address and data pins. In on-chip-only mode, the 64 KB space folds onto the RAM through the low 13 address bits. In off-chip-only mode, everything goes to the external bus. In split mode, the first 8 KB go to the RAM and the rest go to the bus.

The external bus has two pin arrangements:
- **Multiplexed:** a one-cycle address phase with a latch-enable pulse puts the low address byte on the shared data pins.
- **Non-multiplexed:** the whole address stays on the address pins.

In both arrangements, a data phase of a fixed number of cycles follows. The mode and the pin arrangement are sampled only when a request is accepted.

Top module: `xdata_router`

## Requirements
- R1: Target choice at acceptance. Mode 2'b00 sends every address to on-chip RAM. Mode 2'b01 sends addresses below 0x2000 to on-chip RAM and 0x2000 and above to the external bus. Modes 2'b10 and 2'b11 send every address to the external bus.
- R2: An on-chip access drives ram_addr with request address bits 12:0, so the RAM repeats every 8 KB. ram_we equals the request write flag.
- R3: On-chip access timing:
  - ram_en is high in the cycle the request is accepted.
  - rsp_done rises one clock later.
  - rsp_rdata then carries ram_rdata.
- R4: Multiplexed external access (mux_cfg=1):
  - one cycle with ext_ale=1, ext_ad_oe=1, the low address byte on ext_ad_out and ext_addr = {address bits 15:8, 8'h00};
  - then DATA_CYCLES data cycles;
  - rsp_done is seen 2+DATA_CYCLES clocks after acceptance.
- R5: Non-multiplexed external access (mux_cfg=0):
  - ext_ale is never raised;
  - ext_addr carries the full address during the data phase;
  - rsp_done is seen 1+DATA_CYCLES clocks after acceptance.
- R6: External write and read data phases:
  - An external write holds ext_wr_n low with ext_ad_oe=1 and the write byte on ext_ad_out.
  - An external read holds ext_rd_n low with ext_ad_oe=0.
  - A read returns the ext_ad_in value present in its last data cycle.
- R7: rsp_done is a one-cycle pulse. ext_rd_n and ext_wr_n are never both low. An on-chip access raises no external strobe and no latch enable.
- R8: A change on mode_cfg or mux_cfg during an access does not alter that access's target, pin arrangement or length. The next access uses the new values.
- R9: rsp_rdata comes from the target chosen at acceptance. An external read returns bus data, even if the mode has meanwhile changed to on-chip only.
- R10: While rst_n is low at a clock edge, the block returns to idle: rsp_done=0, ext_ale=0, ext_rd_n=ext_wr_n=1, ext_ad_oe=0, ram_en=0 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg | input | 2 | Mapping mode (00 on-chip, 01 split, 10/11 off-chip) |
| mux_cfg | input | 1 | 1 = multiplexed external pins, 0 = separate address pins |
| req_valid | input | 1 | Request present; held until rsp_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_rdata | output | DATA_W | Read byte, valid with rsp_done |
| rsp_done | output | 1 | Access complete (one-cycle pulse) |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | LOCAL_AW | On-chip RAM address |
| ram_wdata | output | DATA_W | On-chip RAM write data |
| ram_rdata | input | DATA_W | On-chip RAM read data, one clock after ram_en |
| ext_addr | output | ADDR_W | External address pins |
| ext_ad_out | output | DATA_W | External data / multiplexed address out |
| ext_ad_oe | output | 1 | Drive enable for ext_ad_out |
| ext_ad_in | input | DATA_W | External data in |
| ext_ale | output | 1 | Address latch enable (multiplexed only) |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The main function is driven with one table of accesses, and the rows are chosen to separate specific failure modes:
- Addresses on either side of 0x2000 under each of the four mode codes show whether the split boundary and the 2'b11 alias are decoded.
- A write at 0x0123 read back at 0xE123, and a write at 0xFFFF against a later on-chip read, tell the 8 KB fold apart from a full-width address.
- Mixing multiplexed and separate-pin accesses of both directions distinguishes the latch phase, the latency of each arrangement and the bus direction.

Directed tests then change mode and pin arrangement in the middle of an external read, which separates acceptance-time sampling from live decoding. A reset in the middle of an access confirms that the block returns to idle.

// File: rtl/xr_pkg.sv
// Shared types for the external data space router.
// Assumes: a single clock domain; all state enums are encoded by the tool.
package xr_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_LDONE,  // on-chip access completing
        ST_ALE,    // multiplexed address phase
        ST_DATA,   // external data phase
        ST_XDONE   // external access completing
    } xr_state_e;

    // Mapping mode codes
    localparam logic [1:0] MODE_LOCAL = 2'b00;
    localparam logic [1:0] MODE_SPLIT = 2'b01;

endpackage

// File: rtl/xr_decode.sv
// Target decoder: says whether an address goes to on-chip RAM.
// Assumes: mode 2'b1x means off-chip only; the split boundary is
// 2**LOCAL_AW, i.e. all address bits above the RAM index are zero.
module xr_decode #(
    parameter int ADDR_W   = 16,
    parameter int LOCAL_AW = 13
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              to_local
);
    import xr_pkg::*;

    logic upper_zero;

    // Detect addresses below the split boundary
    always_comb begin
        upper_zero = (addr[ADDR_W-1:LOCAL_AW] == '0);
    end

    // Pick the target from mode and address
    always_comb begin
        case (mode)
            MODE_LOCAL: to_local = 1'b1;
            MODE_SPLIT: to_local = upper_zero;
            default:    to_local = 1'b0;
        endcase
    end
endmodule

// File: rtl/xr_seq.sv
// Access sequencer: accepts a request when idle, freezes the target and
// pin arrangement, and steps through address and data phases.
// Assumes: the requester holds its inputs until done; DATA_CYCLES >= 1.
module xr_seq #(
    parameter int DATA_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_to_local,
    input  logic              mux_cfg,
    output logic              accept,
    output xr_pkg::xr_state_e state,
    output logic              data_last,
    output logic              tgt_local_q,
    output logic              mux_q
);
    import xr_pkg::*;

    localparam int CW = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_CYCLES - 1);

    xr_state_e     nxt;
    logic [CW-1:0] cnt;

    // Accept a request only in idle
    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        data_last = (state == ST_DATA) && (cnt == LAST);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (req_valid)
                          nxt = req_to_local ? ST_LDONE
                                             : (mux_cfg ? ST_ALE : ST_DATA);
            ST_LDONE: nxt = ST_IDLE;
            ST_ALE:   nxt = ST_DATA;
            ST_DATA:  if (cnt == LAST) nxt = ST_XDONE;
            ST_XDONE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Data-phase cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_DATA) cnt <= '0;
        else if (cnt != LAST)           cnt <= cnt + 1'b1;
    end

    // Freeze target and pin arrangement at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_local_q <= 1'b0;
            mux_q       <= 1'b0;
        end else if (accept) begin
            tgt_local_q <= req_to_local;
            mux_q       <= mux_cfg;
        end
    end
endmodule

// File: rtl/xr_pins.sv
// External pin driver: derives bus pins from the sequencer state and the
// request captured at acceptance.
// Assumes: DATA_W <= ADDR_W; in multiplexed mode the low address byte
// shares the data pins.
module xr_pins #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  xr_pkg::xr_state_e   state,
    input  logic                mux_q,
    input  logic                write_q,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [DATA_W-1:0]   wdata_q,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ext_ad_out,
    output logic                ext_ad_oe,
    output logic                ext_ale,
    output logic                ext_rd_n,
    output logic                ext_wr_n
);
    import xr_pkg::*;

    logic in_ale, in_data, on_bus;

    // Phase flags
    always_comb begin
        in_ale  = (state == ST_ALE);
        in_data = (state == ST_DATA);
        on_bus  = in_ale || in_data || (state == ST_XDONE);
    end

    // Address pins: upper byte only when multiplexed, whole address otherwise
    always_comb begin
        if (!on_bus)    ext_addr = '0;
        else if (mux_q) ext_addr = {addr_q[ADDR_W-1:DATA_W], {DATA_W{1'b0}}};
        else            ext_addr = addr_q;
    end

    // Shared data pins and strobes
    always_comb begin
        ext_ale    = in_ale;
        ext_ad_out = in_ale ? addr_q[DATA_W-1:0] : wdata_q;
        ext_ad_oe  = in_ale || (in_data && write_q);
        ext_rd_n   = !(in_data && !write_q);
        ext_wr_n   = !(in_data && write_q);
    end
endmodule

// File: rtl/xdata_router.sv
// External data space router top: decodes each request to on-chip RAM or
// the external bus, runs the access and returns data with a done pulse.
// Assumes: the on-chip RAM has one-cycle synchronous read; the requester
// holds req_* stable from acceptance until rsp_done.
module xdata_router #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int LOCAL_AW    = 13,
    parameter int DATA_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_cfg,
    input  logic              mux_cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              ram_en,
    output logic              ram_we,
    output logic [LOCAL_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_ad_out,
    output logic              ext_ad_oe,
    input  logic [DATA_W-1:0] ext_ad_in,
    output logic              ext_ale,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    import xr_pkg::*;

    xr_state_e         state;
    logic              to_local, accept, data_last;
    logic              tgt_local_q, mux_q, write_q, busy;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, ext_q;

    xr_decode #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_dec (
        .mode     (mode_cfg),
        .addr     (req_addr),
        .to_local (to_local)
    );

    xr_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_to_local (to_local),
        .mux_cfg      (mux_cfg),
        .accept       (accept),
        .state        (state),
        .data_last    (data_last),
        .tgt_local_q  (tgt_local_q),
        .mux_q        (mux_q)
    );

    xr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state      (state),
        .mux_q      (mux_q),
        .write_q    (write_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .ext_addr   (ext_addr),
        .ext_ad_out (ext_ad_out),
        .ext_ad_oe  (ext_ad_oe),
        .ext_ale    (ext_ale),
        .ext_rd_n   (ext_rd_n),
        .ext_wr_n   (ext_wr_n)
    );

    // Capture the request for the external phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // Capture external read data at the end of the last data cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                     ext_q <= '0;
        else if (data_last && !write_q) ext_q <= ext_ad_in;
    end

    // On-chip RAM port, driven in the acceptance cycle
    always_comb begin
        ram_en    = accept && to_local;
        ram_we    = req_write;
        ram_addr  = req_addr[LOCAL_AW-1:0];
        ram_wdata = req_wdata;
    end

    // Response to the requester
    always_comb begin
        busy      = (state != ST_IDLE);
        rsp_done  = (state == ST_LDONE) || (state == ST_XDONE);
        rsp_rdata = tgt_local_q ? ram_rdata : ext_q;
    end
endmodule

// File: rtl/xr_router_chk.sv
// Protocol checker for the external data space router, bound to the top.
// Assumes: synchronous active-low reset; rst_n is driven from time zero.
module xr_router_chk (
    input logic clk,
    input logic rst_n,
    input logic rsp_done,
    input logic ram_en,
    input logic ext_ale,
    input logic ext_rd_n,
    input logic ext_wr_n,
    input logic ext_ad_oe,
    input logic busy,
    input logic tgt_local_q,
    input logic mux_q
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    // R7
    local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (ext_rd_n && ext_wr_n && !ext_ale));

    // R3
    local_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> rsp_done);

    // R4
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |=> (!ext_ale && (!ext_rd_n || !ext_wr_n)));

    // R5
    nomux_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mux_q) |-> !ext_ale);

    // R6
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> !ext_ad_oe);

    // R8
    hold_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(tgt_local_q) && $stable(mux_q)));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_done && ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe));
endmodule

bind xdata_router xr_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_done    (rsp_done),
    .ram_en      (ram_en),
    .ext_ale     (ext_ale),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_ad_oe   (ext_ad_oe),
    .busy        (busy),
    .tgt_local_q (tgt_local_q),
    .mux_q       (mux_q)
);

// File: tb/xdata_router_test.sv
module xdata_router_test;
    localparam int DC = 2;

    typedef struct packed {
        logic [1:0]  mode;
        logic        mux;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;   // write byte or expected read byte
        logic        loc;    // expected on-chip target
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 1'b0, 1'b1, 16'h0123, 8'h11, 1'b1},
        '{2'b00, 1'b1, 1'b0, 16'hE123, 8'h11, 1'b1},
        '{2'b01, 1'b0, 1'b0, 16'h1FFF, 8'hA5, 1'b1},
        '{2'b01, 1'b1, 1'b1, 16'h2000, 8'h22, 1'b0},
        '{2'b01, 1'b0, 1'b0, 16'h2000, 8'h22, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h0010, 8'hD3, 1'b0},
        '{2'b11, 1'b0, 1'b1, 16'h1000, 8'h33, 1'b0},
        '{2'b11, 1'b1, 1'b0, 16'h1000, 8'h33, 1'b0},
        '{2'b10, 1'b1, 1'b1, 16'hFFFF, 8'h44, 1'b0},
        '{2'b00, 1'b0, 1'b0, 16'hFFFF, 8'hA5, 1'b1},
        '{2'b01, 1'b1, 1'b0, 16'h8000, 8'h43, 1'b0},
        '{2'b00, 1'b0, 1'b1, 16'h1FFF, 8'h55, 1'b1},
        '{2'b01, 1'b0, 1'b0, 16'h1FFF, 8'h55, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_cfg = 2'b00;
    logic        mux_cfg = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata, ram_wdata, ext_ad_out;
    logic        rsp_done, ram_en, ram_we, ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;
    logic [12:0] ram_addr;
    logic [15:0] ext_addr;
    logic [7:0]  ram_q = '0;
    logic [7:0]  ext_ad_in;
    logic [7:0]  lo_latch = '0;
    logic        cur_mux = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    byte unsigned ram_mem [int];
    byte unsigned ext_mem [int];

    always #10 clk = ~clk;

    xdata_router #(.DATA_CYCLES(DC)) uut (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .mux_cfg(mux_cfg),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_q), .ext_addr(ext_addr),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    function automatic logic [7:0] ram_dflt(input logic [12:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ext_dflt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [15:0] ext_full();
        return cur_mux ? {ext_addr[15:8], lo_latch} : ext_addr;
    endfunction

    // On-chip RAM model, one-cycle synchronous read
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
            else ram_q <= ram_mem.exists(int'(ram_addr)) ?
                          ram_mem[int'(ram_addr)] : ram_dflt(ram_addr);
        end
    end

    // External memory model with address latch
    always @(posedge clk) begin
        if (ext_ale) lo_latch <= ext_ad_out;
        if (!ext_wr_n) ext_mem[int'(ext_full())] = ext_ad_out;
    end

    always_comb begin
        if (!ext_rd_n)
            ext_ad_in = ext_mem.exists(int'(ext_full())) ?
                        ext_mem[int'(ext_full())] : ext_dflt(ext_full());
        else
            ext_ad_in = 8'h00;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Run one access; if flip, change mode to 00 and invert mux after cycle 1
    task automatic run(input vec_t v, input bit flip);
        int cyc = 0;
        int ale_n = 0;
        int rd_n = 0;
        int wr_n = 0;
        bit ram_seen;
        bit pin_ok = 1'b1;
        int exp_lat;
        @(negedge clk);
        mode_cfg = v.mode; mux_cfg = v.mux; cur_mux = v.mux;
        req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
        req_valid = 1'b1;
        #1;
        ram_seen = ram_en;
        if (v.loc) begin
            chk(ram_addr == v.addr[12:0] && ram_we == v.wr,
                "R2 ram_addr fold", {ram_we, 3'b0, ram_addr}, {v.wr, 3'b0, v.addr[12:0]});
        end
        while (cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (ext_ale) begin
                ale_n++;
                if (ext_ad_out != v.addr[7:0] || !ext_ad_oe ||
                    ext_addr != {v.addr[15:8], 8'h00}) pin_ok = 1'b0;
            end
            if (!ext_rd_n) begin
                rd_n++;
                if (ext_ad_oe) pin_ok = 1'b0;
            end
            if (!ext_wr_n) begin
                wr_n++;
                if (ext_ad_out != v.data || !ext_ad_oe) pin_ok = 1'b0;
            end
            if ((!ext_rd_n || !ext_wr_n) &&
                ext_addr != (cur_mux ? {v.addr[15:8], 8'h00} : v.addr)) pin_ok = 1'b0;
            if (flip && cyc == 1) begin
                mode_cfg = 2'b00;
                mux_cfg = ~mux_cfg;
            end
            if (rsp_done) break;
        end
        exp_lat = v.loc ? 1 : (cur_mux ? 2 + DC : 1 + DC);
        chk(ram_seen == v.loc, "R1 target choice", ram_seen, v.loc);
        chk(cyc == exp_lat, v.loc ? "R3 on-chip latency" :
            (cur_mux ? "R4 mux latency" : "R5 non-mux latency"), cyc, exp_lat);
        if (v.loc) begin
            chk(ale_n == 0 && rd_n == 0 && wr_n == 0, "R7 on-chip bus quiet",
                ale_n + rd_n + wr_n, 0);
        end else begin
            chk(ale_n == (cur_mux ? 1 : 0), "R4 R5 latch pulse count",
                ale_n, cur_mux ? 1 : 0);
            chk(pin_ok, "R6 external pin values", pin_ok, 1);
            chk(v.wr ? (wr_n == DC && rd_n == 0) : (rd_n == DC && wr_n == 0),
                "R6 strobe cycles", {rd_n[15:0], wr_n[15:0]},
                v.wr ? DC : (DC << 16));
        end
        if (!v.wr) chk(rsp_rdata == v.data, "R9 read data", rsp_rdata, v.data);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_done, "R7 done pulse", rsp_done, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!rsp_done && ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && !ram_en,
            "R10 reset idle", {rsp_done, ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe, ram_en},
            6'b011000);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

        // R8 R9: mode and mux changed mid external read
        run('{2'b01, 1'b0, 1'b0, 16'h3000, 8'hF3, 1'b0}, 1'b1);
        // R8: next access follows the new mode (on-chip, fold of 0x3000)
        run('{2'b00, 1'b0, 1'b0, 16'h3000, 8'h5A, 1'b1}, 1'b0);
        // R8: multiplexed access keeps its latch phase after mux drops
        run('{2'b10, 1'b1, 1'b0, 16'h4567, 8'h67 ^ 8'h45 ^ 8'hC3, 1'b0}, 1'b1);

        // R10 reset in the middle of an external access
        @(negedge clk);
        mode_cfg = 2'b10; mux_cfg = 1'b0; req_write = 1'b1;
        req_addr = 16'h5000; req_valid = 1'b1;
        @(negedge clk);
        chk(!ext_wr_n, "R10 access under way", ext_wr_n, 0);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_done && ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe,
            "R10 reset mid-access", {rsp_done, ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe},
            5'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_done && ext_wr_n, "R10 idle after reset", {rsp_done, ext_wr_n}, 2'b01);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule